// File: doc/BRIEF.md
# Data-Bus Region Decoder with Write Protection

This block sits on the data side of a 32-bit CPU, between the core and the memories. It takes one access per cycle (address and a read/write flag) and sends it to exactly one of four targets: a small tightly coupled local memory, the register bus, a serial-flash window, or external DRAM. DRAM is the fallback when no other window matches. For each access it produces a one-hot target select, an address translated into that target's own space, and a write enable. The write enable is forced low when the write falls in a protected DRAM region.

Software sets up the block through a narrow write-only port: a register index, a 32-bit data word and a strobe. The configuration holds the local-memory mask and match, the register-bus and flash window bases, and the DRAM offset in units of 8-byte words. It also holds two protected regions, each a base and mask pair on address bits [31:16], plus one global protection enable. Results appear one clock after the request. A dropped write still produces a valid result cycle, so the CPU's handshake completes and the core never stalls.

Top module: `dbus_region_decoder`

## Requirements
- R1: After reset every configuration field is zero and protection is off. The output stage is idle: out_valid, out_sel and out_we are all zero. Because the local-memory mask and match are both zero, every access after reset selects local memory.
- R2: A request accepted at a clock edge produces its result at that same edge, so the result is visible during the following cycle. out_valid is high exactly when a request was presented. With out_valid high, exactly one out_sel bit is set: bit 0 local memory, bit 1 register bus, bit 2 flash, bit 3 DRAM. With out_valid low, out_sel and out_we are zero.
- R3: An access targets local memory when (addr & lmem_mask) == lmem_match. The translated address is addr[11:0], zero-extended to 32 bits.
- R4: Decode priority is local memory first, then register bus, then flash window, with DRAM last as the default.
- R5: The register-bus window matches when addr[31:16] equals reg_base[15:0]. The translated address is addr[15:0], zero-extended.
- R6: The flash window matches when addr[31:24] equals flash_base[15:8]. The bits flash_base[7:0] take no part in the match. The translated address is addr[23:0], zero-extended.
- R7: An access that matches no other window goes to DRAM. Its translated address is (dram_base << 3) + addr, taken modulo 2^32.
- R8: When protection is enabled, a write is dropped if, for either region k, (addr[31:16] & wp_mask_k) == wp_base_k. A dropped write keeps out_valid and its target select, and out_we is low.
- R9: With protection disabled, every write gives out_we high, whatever the region settings.
- R10: A read never gives out_we high.
- R11: The configuration indices are: 0 control (bit 0 = protection enable), 1 region 0 and 2 region 1 (data [31:16] = mask, [15:0] = base), 3 lmem_mask, 4 lmem_match, 5 dram_base, 6 reg_base (bits [15:0]), 7 flash_base (bits [15:0]). A write takes effect at the strobe edge. A write to indices 8 to 15 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| req_valid | input | 1 | CPU data access present |
| req_wr | input | 1 | Access is a write |
| req_addr | input | 32 | CPU data address |
| out_valid | output | 1 | Registered result valid |
| out_sel | output | 4 | One-hot target select |
| out_addr | output | 32 | Address translated into the target's space |
| out_we | output | 1 | Write enable after protection filtering |

## Verification
The clocked properties assume that req_valid, req_wr and cfg_we are held low while reset is asserted. The $past-based checks rely on this, because they look at the request sampled one edge earlier. The stimulus therefore keeps every input at zero until reset is released. After that it drives inputs only on falling edges, and it changes the configuration only between accesses, so a checked access never sees a half-applied setting. Address patterns are chosen so that each window, each priority overlap, the DRAM wrap and both protected regions are reached on purpose. Where a bit must be shown to be ignored, it is set to a non-matching value.

// File: rtl/dbr_pkg.sv
package dbr_pkg;
    localparam int ADDR_W    = 32;
    localparam int WIN_W     = 16;
    localparam int NUM_WP    = 2;
    localparam int NUM_TGT   = 4;
    localparam int LMEM_AW   = 12;
    localparam int FLASH_CW  = 8;
    localparam int DRAM_SH   = 3;
    localparam int CIDX_W    = 4;

    localparam logic [CIDX_W-1:0] IDX_CTRL   = 4'd0;
    localparam logic [CIDX_W-1:0] IDX_WP0    = 4'd1;
    localparam logic [CIDX_W-1:0] IDX_LMASK  = IDX_WP0 + CIDX_W'(NUM_WP);
    localparam logic [CIDX_W-1:0] IDX_LMATCH = IDX_LMASK + 4'd1;
    localparam logic [CIDX_W-1:0] IDX_DBASE  = IDX_LMATCH + 4'd1;
    localparam logic [CIDX_W-1:0] IDX_RBASE  = IDX_DBASE + 4'd1;
    localparam logic [CIDX_W-1:0] IDX_FBASE  = IDX_RBASE + 4'd1;

    typedef enum logic [1:0] {
        TGT_LMEM  = 2'd0,
        TGT_REG   = 2'd1,
        TGT_FLASH = 2'd2,
        TGT_DRAM  = 2'd3
    } tgt_e;

    typedef struct packed {
        logic                          prot_en;
        logic [NUM_WP-1:0][WIN_W-1:0]  wp_base;
        logic [NUM_WP-1:0][WIN_W-1:0]  wp_mask;
        logic [ADDR_W-1:0]             lmem_mask;
        logic [ADDR_W-1:0]             lmem_match;
        logic [ADDR_W-1:0]             dram_base;
        logic [WIN_W-1:0]              reg_base;
        logic [WIN_W-1:0]              flash_base;
    } cfg_t;
endpackage

// File: rtl/dbr_cfg_regs.sv
module dbr_cfg_regs
    import dbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CIDX_W-1:0]    cfg_idx,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    output cfg_t                 cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we) begin
            if (cfg_idx == IDX_CTRL)   cfg_d.prot_en    = cfg_wdata[0];
            for (int k = 0; k < NUM_WP; k++) begin
                if (cfg_idx == IDX_WP0 + CIDX_W'(k)) begin
                    cfg_d.wp_base[k] = cfg_wdata[WIN_W-1:0];
                    cfg_d.wp_mask[k] = cfg_wdata[ADDR_W-1:WIN_W];
                end
            end
            if (cfg_idx == IDX_LMASK)  cfg_d.lmem_mask  = cfg_wdata;
            if (cfg_idx == IDX_LMATCH) cfg_d.lmem_match = cfg_wdata;
            if (cfg_idx == IDX_DBASE)  cfg_d.dram_base  = cfg_wdata;
            if (cfg_idx == IDX_RBASE)  cfg_d.reg_base   = cfg_wdata[WIN_W-1:0];
            if (cfg_idx == IDX_FBASE)  cfg_d.flash_base = cfg_wdata[WIN_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;

    // R11
    unused_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_idx > IDX_FBASE) |=> $stable(cfg_q));
endmodule

// File: rtl/dbr_decode.sv
module dbr_decode
    import dbr_pkg::*;
(
    input  cfg_t               cfg,
    input  logic [ADDR_W-1:0]  addr,
    output tgt_e               tgt,
    output logic [ADDR_W-1:0]  taddr
);
    localparam int UPPER_LO = ADDR_W - WIN_W;
    localparam int FLASH_LO = ADDR_W - FLASH_CW;

    logic lmem_hit, reg_hit, flash_hit;
    logic [ADDR_W-1:0] dram_off;

    always_comb begin
        lmem_hit  = (addr & cfg.lmem_mask) == cfg.lmem_match;
        reg_hit   = addr[ADDR_W-1:UPPER_LO] == cfg.reg_base;
        flash_hit = addr[ADDR_W-1:FLASH_LO] == cfg.flash_base[WIN_W-1:WIN_W-FLASH_CW];
        dram_off  = cfg.dram_base << DRAM_SH;

        tgt   = TGT_DRAM;
        taddr = dram_off + addr;
        if (lmem_hit) begin
            tgt   = TGT_LMEM;
            taddr = {{(ADDR_W-LMEM_AW){1'b0}}, addr[LMEM_AW-1:0]};
        end else if (reg_hit) begin
            tgt   = TGT_REG;
            taddr = {{(ADDR_W-WIN_W){1'b0}}, addr[WIN_W-1:0]};
        end else if (flash_hit) begin
            tgt   = TGT_FLASH;
            taddr = {{FLASH_CW{1'b0}}, addr[FLASH_LO-1:0]};
        end
    end
endmodule

// File: rtl/dbr_wprot.sv
module dbr_wprot
    import dbr_pkg::*;
(
    input  cfg_t               cfg,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               wr,
    output logic               hit,
    output logic               we
);
    logic [NUM_WP-1:0] region_hit;

    for (genvar k = 0; k < NUM_WP; k++) begin : g_region
        assign region_hit[k] =
            (addr[ADDR_W-1:ADDR_W-WIN_W] & cfg.wp_mask[k]) == cfg.wp_base[k];
    end

    always_comb begin
        hit = |region_hit;
        we  = wr & ~(cfg.prot_en & hit);
    end
endmodule

// File: rtl/dbus_region_decoder.sv
module dbus_region_decoder
    import dbr_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CIDX_W-1:0]    cfg_idx,
    input  logic [ADDR_W-1:0]    cfg_wdata,
    input  logic                 req_valid,
    input  logic                 req_wr,
    input  logic [ADDR_W-1:0]    req_addr,
    output logic                 out_valid,
    output logic [NUM_TGT-1:0]   out_sel,
    output logic [ADDR_W-1:0]    out_addr,
    output logic                 out_we
);
    typedef struct packed {
        logic                valid;
        logic [NUM_TGT-1:0]  sel;
        logic [ADDR_W-1:0]   addr;
        logic                we;
    } out_t;

    cfg_t              cfg;
    tgt_e              tgt;
    logic [ADDR_W-1:0] taddr;
    logic              prot_hit, filt_we;
    out_t              out_d, out_q;

    dbr_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .cfg(cfg)
    );

    dbr_decode u_dec (.cfg(cfg), .addr(req_addr), .tgt(tgt), .taddr(taddr));

    dbr_wprot u_wp (
        .cfg(cfg), .addr(req_addr), .wr(req_wr), .hit(prot_hit), .we(filt_we)
    );

    always_comb begin
        out_d = '0;
        if (req_valid) begin
            out_d.valid    = 1'b1;
            out_d.sel[tgt] = 1'b1;
            out_d.addr     = taddr;
            out_d.we       = filt_we;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_valid = out_q.valid;
    assign out_sel   = out_q.sel;
    assign out_addr  = out_q.addr;
    assign out_we    = out_q.we;

    // R2
    one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $countones(out_sel) == 1);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> (out_sel == '0 && !out_we));
    // R2
    latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == $past(req_valid));
    // R3
    lmem_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sel[TGT_LMEM]) |-> out_addr[ADDR_W-1:LMEM_AW] == '0);
    // R5
    reg_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_sel[TGT_REG]) |-> out_addr[ADDR_W-1:WIN_W] == '0);
    // R8
    drop_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_wr && cfg.prot_en && prot_hit) |-> (out_valid && !out_we));
    // R9
    prot_off_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && req_wr && !cfg.prot_en) |-> out_we);
    // R10
    read_no_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_valid && !req_wr) |-> !out_we);
endmodule

// File: tb/tb_dbus_region_decoder.sv
module tb_dbus_region_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_idx = '0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_wr = 1'b0;
    logic [31:0] req_addr = '0;
    logic        out_valid;
    logic [3:0]  out_sel;
    logic [31:0] out_addr;
    logic        out_we;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [36:0] exp_q[$];
    string       tag_q[$];

    // shadow configuration, built from the register map in R11
    logic        s_prot = 0;
    logic [15:0] s_wpb[2] = '{16'h0, 16'h0};
    logic [15:0] s_wpm[2] = '{16'h0, 16'h0};
    logic [31:0] s_lmask = 0, s_lmatch = 0, s_dbase = 0;
    logic [15:0] s_rbase = 0, s_fbase = 0;

    always #2.5 clk = ~clk;

    dbus_region_decoder dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .req_valid(req_valid), .req_wr(req_wr),
        .req_addr(req_addr), .out_valid(out_valid), .out_sel(out_sel),
        .out_addr(out_addr), .out_we(out_we)
    );

    function automatic logic [36:0] model(input logic [31:0] a, input logic w);
        logic [3:0]  sel;
        logic [31:0] ta;
        logic        hit;
        if ((a & s_lmask) == s_lmatch) begin sel = 4'b0001; ta = {20'h0, a[11:0]}; end
        else if (a[31:16] == s_rbase)  begin sel = 4'b0010; ta = {16'h0, a[15:0]}; end
        else if (a[31:24] == s_fbase[15:8]) begin sel = 4'b0100; ta = {8'h0, a[23:0]}; end
        else begin sel = 4'b1000; ta = (s_dbase << 3) + a; end
        hit = ((a[31:16] & s_wpm[0]) == s_wpb[0]) || ((a[31:16] & s_wpm[1]) == s_wpb[1]);
        return {sel, ta, w & ~(s_prot & hit)};
    endfunction

    task automatic cfg_write(input logic [3:0] idx, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b0;
        cfg_we = 1'b1; cfg_idx = idx; cfg_wdata = d;
        case (idx)
            4'd0: s_prot = d[0];
            4'd1: begin s_wpb[0] = d[15:0]; s_wpm[0] = d[31:16]; end
            4'd2: begin s_wpb[1] = d[15:0]; s_wpm[1] = d[31:16]; end
            4'd3: s_lmask = d;
            4'd4: s_lmatch = d;
            4'd5: s_dbase = d;
            4'd6: s_rbase = d[15:0];
            4'd7: s_fbase = d[15:0];
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic access(input logic [31:0] a, input logic w, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_wr = w; req_addr = a;
        exp_q.push_back(model(a, w));
        tag_q.push_back(tag);
    endtask

    task automatic idle();
        @(negedge clk);
        req_valid = 1'b0; req_wr = 1'b0;
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            logic [36:0] e;
            string t;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R2: unexpected result sel=%b addr=%h we=%b (expected none)",
                         out_sel, out_addr, out_we);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if ({out_sel, out_addr, out_we} !== e) begin
                    errors++;
                    $display("FAIL %s: got sel=%b addr=%h we=%b expected sel=%b addr=%h we=%b",
                             t, out_sel, out_addr, out_we, e[36:33], e[32:1], e[0]);
                end
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: idle outputs in reset
        checks++;
        if (out_valid !== 1'b0 || out_sel !== 4'b0 || out_we !== 1'b0) begin
            errors++;
            $display("FAIL R1: got valid=%b sel=%b we=%b expected 0 0 0", out_valid, out_sel, out_we);
        end
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 R3: zero mask/match selects local memory; R9 protection off
        access(32'h8000_1234, 1'b0, "R1");
        access(32'hDEAD_BEEF, 1'b1, "R9");
        idle();

        cfg_write(4'd3, 32'hFFFF_F000);
        cfg_write(4'd4, 32'h1000_0000);
        cfg_write(4'd6, 32'h0000_1F00);
        cfg_write(4'd7, 32'h0000_14AB);
        cfg_write(4'd5, 32'h0000_2000);

        access(32'h1000_0ABC, 1'b0, "R3");
        access(32'h1F00_5678, 1'b1, "R5");
        access(32'h14CD_EF01, 1'b0, "R6");   // low base byte AB differs from CD
        access(32'h2000_0010, 1'b1, "R7");
        access(32'h1001_0000, 1'b0, "R3");   // just outside local memory
        idle();

        // R4: local memory over register bus
        cfg_write(4'd3, 32'hFF00_0000);
        cfg_write(4'd4, 32'h1F00_0000);
        access(32'h1F00_0004, 1'b0, "R4");
        idle();
        cfg_write(4'd3, 32'hFFFF_F000);
        cfg_write(4'd4, 32'h1000_0000);
        // R4: register bus over flash
        cfg_write(4'd6, 32'h0000_1400);
        access(32'h1400_0020, 1'b0, "R4");
        access(32'h1401_0020, 1'b0, "R4");
        idle();

        // R7: DRAM offset wraps
        cfg_write(4'd5, 32'hFFFF_FFFF);
        access(32'h0000_0010, 1'b0, "R7");
        idle();

        // R8/R9: protection regions
        cfg_write(4'd1, 32'hF000_2000);
        cfg_write(4'd2, 32'hFFFF_3004);
        access(32'h2100_0000, 1'b1, "R9");
        idle();
        cfg_write(4'd0, 32'h0000_0001);
        access(32'h2100_0000, 1'b1, "R8");
        access(32'h3004_0008, 1'b1, "R8");
        access(32'h3005_0000, 1'b1, "R8");
        access(32'h2100_0000, 1'b0, "R10");
        access(32'h1000_0010, 1'b1, "R8");
        idle();

        // R11: unused index leaves protection on
        cfg_write(4'd9, 32'h0000_0000);
        cfg_write(4'd15, 32'hFFFF_FFFF);
        access(32'h2FFF_0000, 1'b1, "R11");
        access(32'h3FF0_0000, 1'b0, "R11");
        idle();
        // R9: disabling protection passes the same write
        cfg_write(4'd0, 32'h0000_0000);
        access(32'h3004_0008, 1'b1, "R9");
        idle();

        repeat (4) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R2: got %0d results missing expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule